// File: doc/BRIEF.md
# Vendor Configuration and Interrupt-Sense Register Bank

This block is a small set of vendor registers that a host reaches through an indexed byte port. Index F0h holds a configuration byte that selects the card's I/O base and interrupt. The host can overwrite this byte, but the change lasts only until the next host hardware reset. That reset restores the default most recently delivered by the serial EEPROM controller.

The bank also lets software find out which ISA interrupt lines are in use. Writing a load command copies the synchronized levels of eight interrupt lines into a snapshot byte, which the host then reads back. The same command register drives a pull-low enable toward the board's pull-down network.

A third register sends a one-cycle wake-up strobe to an embedded microcontroller that sits in power-down. The strobe bit clears itself after it fires.

Top module: `vendor_cfg_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the configuration byte takes the stored EEPROM default. The snapshot byte, `pull_low_en` and `wake_pulse` all clear to 0.
- R2: When `ee_load` is high at a clock edge, `ee_data` becomes both the stored default and the current configuration byte. `ee_load` wins over a host write to F0h in the same cycle.
- R3: A host write to index F0h replaces the configuration byte at the clock edge. A read of F0h returns that byte, and so does the `cfg_out` port.
- R4: A host write to index F1h with data bit 0 set captures the interrupt lines into the snapshot byte. The lines pass through a two-flop synchronizer first, so a level that has been steady for three clocks before the write edge is the level captured.
- R5: Every host write to index F1h loads data bit 1 into `pull_low_en`. The output holds that value until the next write to F1h.
- R6: A read of index F2h returns the snapshot byte with this mapping: bit0 IRQ3, bit1 IRQ4, bit2 IRQ5, bit3 IRQ7, bit4 IRQ10, bit5 IRQ11, bit6 IRQ12, bit7 IRQ15. Input bit i of `irq_lines` carries the line for snapshot bit i. The snapshot holds its value, whatever the lines do, until the next load command.
- R7: A host write to index F3h with data bit 0 set raises `wake_pulse` for exactly one clock cycle, starting at the write edge. The pulse then ends without further action.
- R8: Reads of the write-only indices F1h and F3h return 0, as do reads of any index outside F0h–F3h. A write to F2h or to any unused index changes no register.
- R9: `host_rdata` is combinational from `host_addr` and `host_rd`, and it is 0 whenever `host_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Host hardware reset, active low, synchronous |
| host_addr | input | 8 | Register index |
| host_wr | input | 1 | Write strobe, one per cycle |
| host_wdata | input | 8 | Write data |
| host_rd | input | 1 | Read enable |
| host_rdata | output | 8 | Read data |
| irq_lines | input | 8 | Raw interrupt line levels |
| pull_low_en | output | 1 | Enables pull-down on the interrupt lines |
| wake_pulse | output | 1 | One-cycle wake-up strobe to the microcontroller |
| ee_load | input | 1 | Default-value load strobe from the EEPROM controller |
| ee_data | input | 8 | Default configuration byte |
| cfg_out | output | 8 | Current configuration byte |

## Verification
The assertions check the following on every cycle:
- the wake strobe lasts one cycle and only follows a F3h write with bit 0 set;
- the pull-low enable and the snapshot change only on a write to F1h;
- the configuration byte changes only on a F0h write or an EEPROM load;
- reads of write-only indices return zero.

Only the bench's scenarios can show the values themselves. These are the exact snapshot taken through the synchronizer for several line patterns, the restoration of the EEPROM default on reset after a software change, the priority of the EEPROM load, and that writes to read-only or unused indices leave every readable register unchanged.

// File: rtl/vendor_cfg_regs.sv
module vendor_cfg_regs #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] IDX_CFG  = 8'hF0,
  parameter logic [AW-1:0] IDX_CMD  = 8'hF1,
  parameter logic [AW-1:0] IDX_STAT = 8'hF2,
  parameter logic [AW-1:0] IDX_WAKE = 8'hF3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic [DW-1:0] irq_lines,
  output logic          pull_low_en,
  output logic          wake_pulse,
  input  logic          ee_load,
  input  logic [DW-1:0] ee_data,
  output logic [DW-1:0] cfg_out
);

  logic [DW-1:0] dflt_q, cfg_q, status_q, sync1_q, sync2_q;
  logic          pull_q, wake_q;

  wire wr_cfg  = host_wr && host_addr == IDX_CFG;
  wire wr_cmd  = host_wr && host_addr == IDX_CMD;
  wire wr_wake = host_wr && host_addr == IDX_WAKE;

  always_ff @(posedge clk) begin
    sync1_q <= irq_lines;
    sync2_q <= sync1_q;
    if (ee_load) dflt_q <= ee_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= dflt_q;
      status_q <= '0;
      pull_q   <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      if (ee_load)     cfg_q <= ee_data;
      else if (wr_cfg) cfg_q <= host_wdata;
      if (wr_cmd) begin
        pull_q <= host_wdata[1];
        if (host_wdata[0]) status_q <= sync2_q;
      end
      wake_q <= wr_wake && host_wdata[0];
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      if (host_addr == IDX_CFG)       host_rdata = cfg_q;
      else if (host_addr == IDX_STAT) host_rdata = status_q;
    end
  end

  assign pull_low_en = pull_q;
  assign wake_pulse  = wake_q;
  assign cfg_out     = cfg_q;

endmodule

module vendor_cfg_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] host_addr,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic       host_rd,
  input logic [7:0] host_rdata,
  input logic       pull_low_en,
  input logic       wake_pulse,
  input logic       ee_load,
  input logic [7:0] cfg_out,
  input logic [7:0] status_q
);
  a_r7_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  a_r7_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_pulse) |-> $past(host_wr && host_addr == 8'hF3 && host_wdata[0]));
  a_r5_pull_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr == 8'hF1) |=> $stable(pull_low_en));
  a_r6_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr == 8'hF1 && host_wdata[0]) |=> $stable(status_q));
  a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ee_load || (host_wr && host_addr == 8'hF0)) |=> $stable(cfg_out));
  a_r8_wo_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && (host_addr == 8'hF1 || host_addr == 8'hF3)) |-> host_rdata == 8'h00);
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |-> host_rdata == 8'h00);
endmodule

bind vendor_cfg_regs vendor_cfg_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
  .pull_low_en(pull_low_en), .wake_pulse(wake_pulse), .ee_load(ee_load),
  .cfg_out(cfg_out), .status_q(status_q)
);

// File: tb/vendor_cfg_regs_bench.sv
module vendor_cfg_regs_bench;
  logic clk = 0, rst_n = 0;
  logic [7:0] host_addr = 0, host_wdata = 0, irq_lines = 0, ee_data = 0;
  logic host_wr = 0, host_rd = 0, ee_load = 0;
  logic [7:0] host_rdata, cfg_out;
  logic pull_low_en, wake_pulse;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  vendor_cfg_regs u_vendor_cfg_regs (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1; #1 d = host_rdata;
    host_rd = 0;
  endtask

  task automatic eeload(logic [7:0] d);
    @(negedge clk); ee_data = d; ee_load = 1;
    @(negedge clk); ee_load = 0;
  endtask

  task automatic snap(logic [7:0] lines);
    logic [7:0] v;
    @(negedge clk); irq_lines = lines;
    repeat (3) @(negedge clk);
    wr(8'hF1, 8'h01);
    rd(8'hF2, v); check("R4/R6 snapshot", v, lines);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    eeload(8'h5A);
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    check("R1 cfg default", cfg_out, 8'h5A);
    check("R1 pull", {7'b0, pull_low_en}, 0);
    check("R1 wake", {7'b0, wake_pulse}, 0);
    rd(8'hF2, v); check("R1 status", v, 0);
    check("R9 idle rdata", host_rdata, 0);
  endtask

  task automatic t_cfg;
    logic [7:0] v;
    wr(8'hF0, 8'h3C);
    rd(8'hF0, v); check("R3 cfg read", v, 8'h3C);
    check("R3 cfg_out", cfg_out, 8'h3C);
    @(negedge clk); host_addr = 8'hF0; host_wdata = 8'h11; host_wr = 1;
    ee_data = 8'hA7; ee_load = 1;
    @(negedge clk); host_wr = 0; ee_load = 0;
    check("R2 load priority", cfg_out, 8'hA7);
    wr(8'hF0, 8'h99);
    rst_n = 0; @(negedge clk); rst_n = 1;
    check("R1 revert to default", cfg_out, 8'hA7);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    snap(8'hA5); snap(8'h3C); snap(8'hFF);
    @(negedge clk); irq_lines = 8'h00; repeat (4) @(negedge clk);
    rd(8'hF2, v); check("R6 hold while lines change", v, 8'hFF);
    wr(8'hF1, 8'h00);
    rd(8'hF2, v); check("R6 no capture without bit0", v, 8'hFF);
  endtask

  task automatic t_pull;
    wr(8'hF1, 8'h02); check("R5 pull set", {7'b0, pull_low_en}, 1);
    wr(8'hF0, 8'h44); check("R5 pull hold", {7'b0, pull_low_en}, 1);
    wr(8'hF1, 8'h01); check("R5 pull clear", {7'b0, pull_low_en}, 0);
  endtask

  task automatic t_wake;
    logic [7:0] v;
    @(negedge clk); host_addr = 8'hF3; host_wdata = 8'h01; host_wr = 1;
    @(negedge clk); host_wr = 0;
    check("R7 pulse high", {7'b0, wake_pulse}, 1);
    @(negedge clk); check("R7 pulse ends", {7'b0, wake_pulse}, 0);
    wr(8'hF3, 8'h00); check("R7 no pulse bit0 clear", {7'b0, wake_pulse}, 0);
    rd(8'hF3, v); check("R8 F3 reads zero", v, 0);
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    logic [7:0] c, s;
    rd(8'hF0, c); rd(8'hF2, s);
    wr(8'hF2, 8'h5C); wr(8'h7E, 8'hFF);
    rd(8'hF0, v); check("R8 cfg untouched", v, c);
    rd(8'hF2, v); check("R8 status untouched", v, s);
    check("R8 pull untouched", {7'b0, pull_low_en}, 0);
    rd(8'hF1, v); check("R8 F1 reads zero", v, 0);
    rd(8'h7E, v); check("R8 unused reads zero", v, 0);
  endtask

  initial begin
    fork
      begin
        t_reset; t_cfg; t_irq; t_pull; t_wake; t_ignored;
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule